// File: doc/BRIEF.md
# Asynchronous SRAM Timing Controller

This block sits between a synchronous client and an external asynchronous static RAM of 32K words by 8 bits. The client presents a single request: a valid strobe, a write/read flag, a 15-bit address and, for writes, a data byte. The controller then runs one complete memory cycle on the active-low select, write-enable and output-enable strobes. It drives the shared 8-bit data bus only in the window where this is safe. When the cycle ends, it raises `done` for one clock, together with the captured byte on reads.

The timing requirements of the memory are given in nanoseconds and passed in as parameters, together with the clock period. Every interval becomes a whole number of clock cycles by ceiling division, so the strobe waveform holds for any clock period. At the default 20 ns clock the phases are as follows. A read holds select and output enable low for 4 cycles. A write holds select and write enable low for 4 cycles: the first 2 leave the bus floating while the memory's outputs turn off, and in the last 2 the controller drives the data. One more hold cycle follows, with the strobes high and the data still driven.

The control is a five-state machine:
- `ST_IDLE`: all strobes are high and the bus is released.
- `ST_RD_ACCESS`: the read access phase.
- `ST_WR_FLOAT`: write enable is low and the bus is not driven.
- `ST_WR_DRIVE`: write enable is low and the data is driven.
- `ST_WR_HOLD`: the strobes are high and the data is still driven.

The transitions are:
- IDLE→RD_ACCESS on a read request.
- IDLE→WR_FLOAT on a write request.
- RD_ACCESS→IDLE when the access count expires, with data capture and done.
- WR_FLOAT→WR_DRIVE when the float count expires.
- WR_DRIVE→WR_HOLD when the write pulse count expires.
- WR_HOLD→IDLE after one cycle, with done.

Top module: `sram_seq_ctrl`

## Requirements
- R1: After reset, and whenever `busy` is 0, `mem_cs_n`, `mem_we_n` and `mem_oe_n` are all 1, the controller does not drive `mem_dq`, and `done` and `rdata` reset to 0.
- R2: A read request accepted at a clock edge holds `mem_cs_n`=0, `mem_oe_n`=0 and `mem_we_n`=1 from that edge for the read count (4 cycles at 20 ns). During this time `mem_addr` equals the requested address.
- R3: On a read, the byte on `mem_dq` at the last edge of the access is loaded into `rdata`. At the same edge the strobes rise and `done` goes to 1 for exactly one cycle, which is 5 falling edges after acceptance at defaults.
- R4: A write holds `mem_cs_n`=0 and `mem_we_n`=0 with `mem_oe_n`=1 for the float count plus the drive count (4 cycles at defaults). Both strobes rise on the same edge.
- R5: During a write, the controller leaves the bus undriven for the float count (2 cycles). It then drives the write byte for the drive count (2 cycles) before `mem_we_n` rises, and for one hold cycle after.
- R6: `busy` is 1 from the accepting edge until the edge that ends the transaction. At that edge `done` pulses and `busy` falls, 6 falling edges after acceptance for a write at defaults.
- R7: Requests presented while `busy` is 1 are ignored: address and strobes do not change and no extra memory cycle follows.
- R8: A request held valid is accepted on the first edge after `busy` falls. This leaves exactly one cycle with all strobes high between two transactions.
- R9: The controller never drives `mem_dq` while `mem_oe_n` is 0.
- R10: `mem_addr` is stable for as long as `mem_cs_n` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request strobe, sampled while idle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 15 | Word address |
| req_wdata | input | 8 | Write byte |
| busy | output | 1 | A memory cycle is in progress |
| done | output | 1 | One-cycle end-of-transaction pulse |
| rdata | output | 8 | Last byte read |
| mem_addr | output | 15 | Memory address bus |
| mem_dq | inout | 8 | Memory data bus |
| mem_cs_n | output | 1 | Memory select, active low |
| mem_we_n | output | 1 | Memory write enable, active low |
| mem_oe_n | output | 1 | Memory output enable, active low |

## Verification
A wrong state or a mistimed counter in this controller shows up on the strobes within the same transaction. A phase that is one cycle short shortens the low time of select or write enable. The memory model reports this on the edge where the strobe rises. A read that captures too early loads the model's poison byte instead of the stored data, and the next `rdata` comparison shows it. A write whose data is driven too late commits the wrong byte, which the read-back two transactions later exposes. A controller that keeps driving into a read shows at once as a disagreement between the bus and the byte the model drives.

// File: rtl/sram_seq_pkg.sv
package sram_seq_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RD_ACCESS,
        ST_WR_FLOAT,
        ST_WR_DRIVE,
        ST_WR_HOLD
    } seq_state_t;

    // Nanoseconds to whole clock cycles, rounded up; zero stays zero.
    function automatic int ns_to_cyc(input int ns, input int clk_ns);
        if (ns <= 0) return 0;
        return (ns + clk_ns - 1) / clk_ns;
    endfunction

    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/sram_seq_timer.sv
module sram_seq_timer #(
    parameter int CNT_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             expired
);

    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= load_val;
        end else if (cnt != '0) begin
            cnt <= cnt - 1'b1;
        end
    end

    assign expired = (cnt == '0);

endmodule

// File: rtl/sram_seq_io.sv
module sram_seq_io #(
    parameter int ADDR_W = 15,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              latch_req,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic              drive_nxt,
    input  logic              capture,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] rdata,
    output logic              drive,
    inout  wire  [DATA_W-1:0] mem_dq
);

    logic [DATA_W-1:0] wdata_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mem_addr <= '0;
            wdata_q  <= '0;
        end else if (latch_req) begin
            mem_addr <= req_addr;
            wdata_q  <= req_wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            drive <= 1'b0;
        end else begin
            drive <= drive_nxt;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rdata <= '0;
        end else if (capture) begin
            rdata <= mem_dq;
        end
    end

    assign mem_dq = drive ? wdata_q : {DATA_W{1'bz}};

endmodule

// File: rtl/sram_seq_ctrl.sv
module sram_seq_ctrl
    import sram_seq_pkg::*;
#(
    parameter int CLK_NS    = 20,
    parameter int ADDR_W    = 15,
    parameter int DATA_W    = 8,
    parameter int T_RC_NS   = 70,
    parameter int T_AA_NS   = 70,
    parameter int T_AOE_NS  = 35,
    parameter int T_WC_NS   = 70,
    parameter int T_CW_NS   = 55,
    parameter int T_AW_NS   = 55,
    parameter int T_WP_NS   = 40,
    parameter int T_DW_NS   = 35,
    parameter int T_WHZ_NS  = 25,
    parameter int T_OHZ_NS  = 30
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              busy,
    output logic              done,
    output logic [DATA_W-1:0] rdata,
    output logic [ADDR_W-1:0] mem_addr,
    inout  wire  [DATA_W-1:0] mem_dq,
    output logic              mem_cs_n,
    output logic              mem_we_n,
    output logic              mem_oe_n
);

    // Read access: long enough for cycle time, address access and output enable access.
    localparam int RD_CYC  = imax(imax(ns_to_cyc(T_RC_NS, CLK_NS), ns_to_cyc(T_AA_NS, CLK_NS)),
                                  imax(ns_to_cyc(T_AOE_NS, CLK_NS), 1));
    // Bus float wait after write enable falls (also covers a preceding read's turn-off).
    localparam int FLT_CYC = imax(imax(ns_to_cyc(T_WHZ_NS, CLK_NS), ns_to_cyc(T_OHZ_NS, CLK_NS)), 1);
    // Minimum write-enable low time from pulse width, select and address windows.
    localparam int WLOW_CYC = imax(imax(ns_to_cyc(T_WP_NS, CLK_NS), ns_to_cyc(T_CW_NS, CLK_NS)),
                                   ns_to_cyc(T_AW_NS, CLK_NS));
    // Driven part of the pulse: data setup, remaining pulse width, overall cycle time.
    localparam int WD_CYC  = imax(imax(ns_to_cyc(T_DW_NS, CLK_NS), 1),
                                  imax(WLOW_CYC - FLT_CYC, ns_to_cyc(T_WC_NS, CLK_NS) - FLT_CYC - 1));
    localparam int MAX_CYC = imax(RD_CYC, imax(FLT_CYC, WD_CYC));
    localparam int CNT_W   = imax($clog2(MAX_CYC + 1), 1);

    seq_state_t       state, nstate;
    logic             tmr_load;
    logic [CNT_W-1:0] tmr_val;
    logic             tmr_expired;
    logic             latch_req;
    logic             capture;
    logic             drive_nxt;
    logic             dq_drive;

    // ---------------- next-state logic ----------------
    always_comb begin
        nstate = state;
        unique case (state)
            ST_IDLE: begin
                if (req_valid) nstate = req_write ? ST_WR_FLOAT : ST_RD_ACCESS;
            end
            ST_RD_ACCESS: begin
                if (tmr_expired) nstate = ST_IDLE;
            end
            ST_WR_FLOAT: begin
                if (tmr_expired) nstate = ST_WR_DRIVE;
            end
            ST_WR_DRIVE: begin
                if (tmr_expired) nstate = ST_WR_HOLD;
            end
            ST_WR_HOLD: begin
                nstate = ST_IDLE;
            end
            default: nstate = ST_IDLE;
        endcase
    end

    // Phase length loaded on every state change: duration N -> load N-1.
    always_comb begin
        tmr_load = (nstate != state);
        unique case (nstate)
            ST_RD_ACCESS: tmr_val = CNT_W'(RD_CYC - 1);
            ST_WR_FLOAT:  tmr_val = CNT_W'(FLT_CYC - 1);
            ST_WR_DRIVE:  tmr_val = CNT_W'(WD_CYC - 1);
            default:      tmr_val = '0;
        endcase
    end

    assign latch_req = (state == ST_IDLE) && req_valid;
    assign capture   = (state == ST_RD_ACCESS) && tmr_expired;
    assign drive_nxt = (nstate == ST_WR_DRIVE) || (nstate == ST_WR_HOLD);

    // ---------------- state register ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= nstate;
        end
    end

    // ---------------- registered outputs ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mem_cs_n <= 1'b1;
            mem_we_n <= 1'b1;
            mem_oe_n <= 1'b1;
            busy     <= 1'b0;
            done     <= 1'b0;
        end else begin
            mem_cs_n <= !((nstate == ST_RD_ACCESS) || (nstate == ST_WR_FLOAT) ||
                          (nstate == ST_WR_DRIVE));
            mem_we_n <= !((nstate == ST_WR_FLOAT) || (nstate == ST_WR_DRIVE));
            mem_oe_n <= !(nstate == ST_RD_ACCESS);
            busy     <= (nstate != ST_IDLE);
            done     <= (state != ST_IDLE) && (nstate == ST_IDLE);
        end
    end

    sram_seq_timer #(
        .CNT_W (CNT_W)
    ) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .expired  (tmr_expired)
    );

    sram_seq_io #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) u_io (
        .clk       (clk),
        .rst_n     (rst_n),
        .latch_req (latch_req),
        .req_addr  (req_addr),
        .req_wdata (req_wdata),
        .drive_nxt (drive_nxt),
        .capture   (capture),
        .mem_addr  (mem_addr),
        .rdata     (rdata),
        .drive     (dq_drive),
        .mem_dq    (mem_dq)
    );

endmodule

// File: rtl/sram_seq_checker.sv
module sram_seq_checker #(
    parameter int ADDR_W = 15
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              busy,
    input logic              done,
    input logic              mem_cs_n,
    input logic              mem_we_n,
    input logic              mem_oe_n,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              dq_drive
);

    p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (mem_cs_n && mem_we_n && mem_oe_n && !dq_drive));

    p_done_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    p_write_strobes_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_we_n |-> (mem_oe_n && !mem_cs_n));

    p_we_cs_release_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_we_n) |-> $rose(mem_cs_n));

    p_float_first_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dq_drive) |-> (!mem_we_n && $past(!mem_we_n)));

    p_hold_drive_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_we_n) |-> dq_drive);

    p_done_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    p_start_from_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(mem_cs_n) |-> ($past(!busy) && $past(req_valid)));

    p_no_contention_r9: assert property (@(posedge clk) disable iff (!rst_n)
        dq_drive |-> mem_oe_n);

    p_addr_stable_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_cs_n && $past(!mem_cs_n)) |-> $stable(mem_addr));

endmodule

bind sram_seq_ctrl sram_seq_checker #(
    .ADDR_W (ADDR_W)
) u_seq_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .busy      (busy),
    .done      (done),
    .mem_cs_n  (mem_cs_n),
    .mem_we_n  (mem_we_n),
    .mem_oe_n  (mem_oe_n),
    .mem_addr  (mem_addr),
    .dq_drive  (dq_drive)
);

// File: tb/tb_sram_seq_ctrl.sv
module tb_sram_seq_ctrl;

    localparam int AW = 15;
    localparam int DW = 8;
    localparam int N_VEC = 11;
    // {write, addr, wdata, expected rdata}
    localparam logic [31:0] VEC [N_VEC] = '{
        {1'b1, 15'h0000, 8'h5A, 8'h00},
        {1'b1, 15'h7FFF, 8'hA5, 8'h00},
        {1'b1, 15'h1234, 8'h3C, 8'h00},
        {1'b1, 15'h0ABC, 8'hC3, 8'h00},
        {1'b0, 15'h0000, 8'h00, 8'h5A},
        {1'b0, 15'h7FFF, 8'h00, 8'hA5},
        {1'b0, 15'h1234, 8'h00, 8'h3C},
        {1'b1, 15'h1234, 8'h81, 8'h00},
        {1'b0, 15'h1234, 8'h00, 8'h81},
        {1'b0, 15'h0ABC, 8'h00, 8'hC3},
        {1'b0, 15'h0101, 8'h00, 8'h00}
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic          req_write = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic [DW-1:0] req_wdata = '0;
    logic          busy, done;
    logic [DW-1:0] rdata;
    logic [AW-1:0] mem_addr;
    wire  [DW-1:0] mem_dq;
    logic          mem_cs_n, mem_we_n, mem_oe_n;

    int n_checks = 0;
    int n_err = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    sram_seq_ctrl dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_write (req_write),
        .req_addr  (req_addr),
        .req_wdata (req_wdata),
        .busy      (busy),
        .done      (done),
        .rdata     (rdata),
        .mem_addr  (mem_addr),
        .mem_dq    (mem_dq),
        .mem_cs_n  (mem_cs_n),
        .mem_we_n  (mem_we_n),
        .mem_oe_n  (mem_oe_n)
    );

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // ---------------- synchronous behavioural memory model ----------------
    logic [DW-1:0] mdl_mem [int];
    logic [DW-1:0] mdl_out = 8'hEE;
    int            rd_cnt = 0, cs_cnt = 0, we_cnt = 0;
    logic [DW-1:0] dq_h0 = '0, dq_h1 = '0;
    wire           mdl_drive = !mem_cs_n && mem_we_n && !mem_oe_n;

    assign mem_dq = mdl_drive ? mdl_out : {DW{1'bz}};

    always @(posedge clk) begin
        if (rst_n) begin
            if (mdl_drive) begin
                rd_cnt  <= rd_cnt + 1;
                mdl_out <= (rd_cnt + 1 >= 3) ?
                           (mdl_mem.exists(int'(mem_addr)) ? mdl_mem[int'(mem_addr)] : 8'h00) : 8'hEE;
            end else begin
                rd_cnt  <= 0;
                mdl_out <= 8'hEE;
            end
            if (!mem_cs_n) begin
                cs_cnt <= cs_cnt + 1;
            end else if (cs_cnt > 0) begin
                check(cs_cnt >= 4, "R2/R4 model: select low time", cs_cnt, 4);
                cs_cnt <= 0;
            end
            if (!mem_we_n) begin
                we_cnt <= we_cnt + 1;
                dq_h1  <= dq_h0;
                dq_h0  <= mem_dq;
            end else if (we_cnt > 0) begin
                check(we_cnt >= 3, "R4 model: write pulse width", we_cnt, 3);
                check(dq_h1 == dq_h0, "R5 model: data setup before write end", dq_h1, dq_h0);
                mdl_mem[int'(mem_addr)] = dq_h0;
                we_cnt <= 0;
            end
        end
    end

    always @(negedge clk) begin
        if (rst_n && mdl_drive && (mem_dq !== mdl_out))
            check(1'b0, "R9 model: bus contention during read", mem_dq, mdl_out);
    end

    // ---------------- transaction task ----------------
    task automatic run_txn(input logic w, input logic [AW-1:0] a, input logic [DW-1:0] d,
                           output int lat, output int cs_low, output int we_low,
                           output int oe_low, output int drv_ok, output bit busy_n1);
        @(negedge clk);
        req_valid = 1'b1; req_write = w; req_addr = a; req_wdata = d;
        @(negedge clk);
        req_valid = 1'b0;
        lat = 1; cs_low = 0; we_low = 0; oe_low = 0; drv_ok = 0;
        busy_n1 = busy;
        while (!done && lat < 50) begin
            if (!mem_cs_n) begin
                cs_low++;
                check(mem_addr == a, "R10 address during strobes", mem_addr, a);
            end
            if (!mem_we_n) we_low++;
            if (!mem_oe_n) oe_low++;
            if (w && lat >= 3 && mem_dq == d) drv_ok++;
            @(negedge clk);
            lat++;
        end
        if (w && lat >= 3 && mem_dq == d) drv_ok++;
    endtask

    // ---------------- stimulus ----------------
    initial begin
        int lat, csl, wel, oel, drv;
        bit b1;
        repeat (3) @(negedge clk);
        // R1: reset state
        check(mem_cs_n && mem_we_n && mem_oe_n, "R1 strobes during reset",
              {mem_cs_n, mem_we_n, mem_oe_n}, 3'b111);
        rst_n = 1'b1;
        @(negedge clk);
        check(!busy && !done, "R1 busy/done after reset", {busy, done}, 2'b00);
        check(rdata == 8'h00, "R1 rdata after reset", rdata, 8'h00);

        // table walk
        for (int i = 0; i < N_VEC; i++) begin
            run_txn(VEC[i][31], VEC[i][30:16], VEC[i][15:8], lat, csl, wel, oel, drv, b1);
            check(b1, "R6 busy after accept", b1, 1);
            check(csl == 4, "R2/R4 select low cycles", csl, 4);
            if (VEC[i][31]) begin
                check(lat == 6, "R6 write done latency", lat, 6);
                check(wel == 4 && oel == 0, "R4 write strobes", {wel[7:0], oel[7:0]}, 16'h0400);
                check(drv == 3, "R5 driven cycles seen", drv, 3);
            end else begin
                check(lat == 5, "R3 read done latency", lat, 5);
                check(oel == 4 && wel == 0, "R2 read strobes", {oel[7:0], wel[7:0]}, 16'h0400);
                check(rdata == VEC[i][7:0], "R3 read data", rdata, VEC[i][7:0]);
            end
            @(negedge clk);
            check(!done, "R3 done is one cycle", done, 0);
            check(mem_cs_n && mem_we_n && mem_oe_n && !busy, "R1 idle after transaction",
                  {mem_cs_n, mem_we_n, mem_oe_n, busy}, 4'b1110);
        end

        // R7: request while busy is ignored
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b0; req_addr = 15'h7FFF;
        @(negedge clk);
        req_write = 1'b1; req_addr = 15'h0000; req_wdata = 8'hFF;
        while (!done) begin
            check(mem_addr == 15'h7FFF, "R7 address unchanged while busy", mem_addr, 15'h7FFF);
            @(negedge clk);
        end
        req_valid = 1'b0;
        check(rdata == 8'hA5, "R7 first read data", rdata, 8'hA5);
        for (int k = 0; k < 4; k++) begin
            @(negedge clk);
            check(mem_cs_n && !busy, "R7 no extra transaction", {mem_cs_n, busy}, 2'b10);
        end
        run_txn(1'b0, 15'h0000, 8'h00, lat, csl, wel, oel, drv, b1);
        check(rdata == 8'h5A, "R7 ignored write left memory unchanged", rdata, 8'h5A);

        // R8: request held valid is taken right after the previous one
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b0; req_addr = 15'h1234;
        @(negedge clk);
        while (!done) @(negedge clk);
        check(mem_cs_n, "R8 one idle cycle between transactions", mem_cs_n, 1);
        @(negedge clk);
        check(!mem_cs_n && busy, "R8 next transaction accepted at once", {mem_cs_n, busy}, 2'b01);
        req_valid = 1'b0;
        while (!done) @(negedge clk);
        check(rdata == 8'h81, "R8 back-to-back read data", rdata, 8'h81);

        repeat (3) @(negedge clk);
        if (!finished) begin
            finished = 1'b1;
            $display("Result: errors=%0d of %0d checks", n_err, n_checks);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            n_checks++;
            n_err++;
            $display("FAIL watchdog expired (all requirements) actual=hung expected=complete");
            $display("Result: errors=%0d of %0d checks", n_err, n_checks);
            $finish;
        end
    end

endmodule